// File: doc/BRIEF.md
# Four-Axis Game Port Position Timer

This block measures the positions of a four-axis analogue game controller. Each axis sits behind a one-shot timing circuit. The circuit holds a comparator output high for a time that depends on the potentiometer position. That circuit is outside the block, and each axis appears here as one digital comparator input. A write to the axis-value strobe starts a measurement. From then on, every enabled axis has its own counter, which advances at a programmable rate until its comparator input drops low. When all enabled counters have stopped, the counts are copied into result latches and a ready flag is raised.

Software sees three narrow registers through simple read and write strobes, with one shared write-data bus:

- An 8-bit control register: axis enables, readout select, continuous mode, and the ready flag.
- A 4-bit hardware setup register, which reads back as 8 bits.
- A 16-bit readout of the axis chosen by the select field.

An interrupt line signals a completed measurement. It can also be raised by a write to the legacy port strobe.

In continuous mode, each completed measurement latches its results and a new measurement starts at once. The latched values therefore track the controller without further writes.

Top module: `joy_axis_timer`

## Requirements
- R1: After reset, `cfg_rdata`, `hw_rdata`, `axis_rdata` and `irq` are all zero for every readout select.
- R2: Control bits 3:0 enable axes 0 to 3. An axis whose enable bit is clear when a measurement starts does not count, and its latched result is 0 after that measurement.
- R3: `axis_rdata` returns the latched result of the axis numbered by control bits 5:4: 0 gives axis 0 and 3 gives axis 3.
- R4: A pulse on `axis_wr` clears all counters and starts a measurement. Suppose an enabled axis has its comparator high at the start edge and for the following N clock edges, and low at edge N+1. Its result is then floor(N / D), where D is the rate divisor.
- R5: Hardware bits 2:1 select the rate divisor D: code 00 gives 1, code 10 gives 2, code 01 gives 20 and code 11 gives 200.
- R6: An axis counter saturates at 0xFFFF and never wraps.
- R7: Control bit 7 reads 1 once every enabled axis has stopped after a start. A pulse on `cfg_rd` clears both that flag and `irq`. Bit 7 cannot be written.
- R8: When hardware bit 0 is 1, completion of a measurement asserts `irq`. When hardware bit 0 is 0, `irq` stays low on completion.
- R9: With control bit 6 set, each completion latches the results, sets the ready flag and restarts the measurement at once. With bit 6 clear, no further completion follows.
- R10: A pulse on `legacy_wr` asserts `irq` only when three conditions hold together: hardware bit 3 (legacy port enable) is 1, hardware bit 0 is 1, and at least one of control bits 3:0 is 1. Otherwise the pulse has no effect.
- R11: Bits 7:4 of `hw_rdata` always read 0, and bits 3:0 return the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdata | input | 8 | Shared write data for the control and hardware registers |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_rd | input | 1 | Read strobe for the control register; clears ready and irq |
| hw_wr | input | 1 | Write strobe for the hardware setup register |
| axis_wr | input | 1 | Write strobe for the axis-value register; starts a measurement |
| legacy_wr | input | 1 | Write strobe for the legacy port |
| cmp_in | input | 4 | Comparator inputs, one per axis, high while the one-shot runs |
| cfg_rdata | output | 8 | Control register: ready flag in bit 7 and stored bits 6:0 |
| hw_rdata | output | 8 | Hardware setup register, upper nibble zero |
| axis_rdata | output | 16 | Latched result of the selected axis |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the strobes are single-cycle pulses and that the comparator inputs are synchronous to `clk`. They also assume that the rate code does not change while a tick is in flight; if it does change, only the spacing check on consecutive ticks would be affected. The stimulus keeps within these limits. Every strobe is driven on the falling edge and removed one cycle later. Comparator levels change only on falling edges, according to a per-axis edge count chosen in advance. The hardware setup register is rewritten only between measurements. Random enables, selects, rates and edge counts are mixed with directed cases for saturation, continuous mode and the legacy interrupt gating.

// File: rtl/joy_pkg.sv
package joy_pkg;
  localparam int AXES  = 4;
  localparam int SEL_W = 2;

  // Rate code to divisor; code bit 0 picks the slow pair, bit 1 the slower member
  function automatic logic [7:0] rate_divisor(input logic [1:0] code);
    case (code)
      2'b00:   rate_divisor = 8'd1;
      2'b10:   rate_divisor = 8'd2;
      2'b01:   rate_divisor = 8'd20;
      default: rate_divisor = 8'd200;
    endcase
  endfunction
endpackage

// File: rtl/joy_prescaler.sv
module joy_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  import joy_pkg::*;

  logic [PRE_W-1:0] pcnt;
  logic [7:0]       div;

  assign div  = rate_divisor(rate);
  assign tick = run && !restart && (pcnt >= PRE_W'(div - 8'd1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pcnt <= '0;
    else if (run)          pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || div == 8'd1));
endmodule

// File: rtl/joy_axis_counter.sv
module joy_axis_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             enable,
  input  logic             cmp,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             running
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (start) begin
      count   <= '0;
      running <= enable;
    end else if (running) begin
      if (!cmp || count == MAXV) running <= 1'b0;
      else if (tick)             count   <= count + 1'b1;
    end
  end

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV && !start) |=> count == MAXV);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(count));
  // R4
  cmp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cmp && !start) |=> !running);
  // R2
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !enable) |=> (!running && count == '0));
endmodule

// File: rtl/joy_axis_timer.sv
module joy_axis_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       wdata,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic             hw_wr,
  input  logic             axis_wr,
  input  logic             legacy_wr,
  input  logic [3:0]       cmp_in,
  output logic [7:0]       cfg_rdata,
  output logic [7:0]       hw_rdata,
  output logic [CNT_W-1:0] axis_rdata,
  output logic             irq
);
  import joy_pkg::*;

  logic [6:0]       cfg_q;
  logic [3:0]       hw_q;
  logic             ready_q, irq_q, busy_q;
  logic [CNT_W-1:0] counts  [AXES];
  logic [CNT_W-1:0] results [AXES];
  logic [AXES-1:0]  running;
  logic             tick;

  // named internal events
  logic all_done, cont_mode, start, done_evt, legacy_evt, irq_set;
  logic [AXES-1:0] axis_en;
  logic [SEL_W-1:0] sel;
  logic unused_wbits;

  assign axis_en    = cfg_q[AXES-1:0];
  assign sel        = cfg_q[5:4];
  assign cont_mode  = cfg_q[6];
  assign all_done   = busy_q && (running == '0);
  assign done_evt   = all_done && !axis_wr;
  assign start      = axis_wr || (done_evt && cont_mode);
  assign legacy_evt = legacy_wr && hw_q[3] && hw_q[0] && (axis_en != '0);
  assign irq_set    = (done_evt && hw_q[0]) || legacy_evt;
  assign unused_wbits = wdata[7];

  joy_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(start), .run(busy_q),
    .rate(hw_q[2:1]), .tick(tick)
  );

  for (genvar i = 0; i < AXES; i++) begin : g_axis
    joy_axis_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start), .enable(axis_en[i]),
      .cmp(cmp_in[i]), .tick(tick), .count(counts[i]), .running(running[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)        results[i] <= '0;
      else if (done_evt) results[i] <= counts[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      hw_q    <= '0;
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= wdata[6:0];
      if (hw_wr)  hw_q  <= wdata[3:0];

      if (axis_wr) begin
        busy_q  <= 1'b1;
        ready_q <= 1'b0;
      end else if (done_evt) begin
        busy_q  <= cont_mode;
        ready_q <= 1'b1;
      end else if (cfg_rd) begin
        ready_q <= 1'b0;
      end

      if (irq_set)     irq_q <= 1'b1;
      else if (cfg_rd) irq_q <= 1'b0;
    end
  end

  assign cfg_rdata  = {ready_q, cfg_q};
  assign hw_rdata   = {4'b0000, hw_q};
  assign axis_rdata = results[sel];
  assign irq        = irq_q;

  // R7
  ready_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(busy_q && running == '0));
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !busy_q) |=> (!ready_q && !irq_q));
  // R8
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !hw_q[0]) |=> !irq_q);
  // R10
  legacy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !busy_q && !hw_q[3]) |=> !irq_q);
  // R9
  cont_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && cont_mode) |=> busy_q);
endmodule

// File: tb/joy_axis_timer_tb.sv
module joy_axis_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  wdata = '0;
  logic        cfg_wr = 0, cfg_rd = 0, hw_wr = 0, axis_wr = 0, legacy_wr = 0;
  logic [3:0]  cmp_in = '0;
  logic [7:0]  cfg_rdata, hw_rdata;
  logic [15:0] axis_rdata;
  logic        irq;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  joy_axis_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .hw_wr(hw_wr), .axis_wr(axis_wr), .legacy_wr(legacy_wr), .cmp_in(cmp_in),
    .cfg_rdata(cfg_rdata), .hw_rdata(hw_rdata), .axis_rdata(axis_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // divisor restated from the rate requirement
  function automatic int bench_div(input logic [1:0] code);
    if (code[0]) return code[1] ? 200 : 20;
    return code[1] ? 2 : 1;
  endfunction

  function automatic logic [15:0] exp_count(input int n, input logic [1:0] code);
    int q = n / bench_div(code);
    return (q > 65535) ? 16'hFFFF : 16'(q);
  endfunction

  task automatic strobe_wr(input int which, input logic [7:0] v);
    @(negedge clk);
    wdata = v;
    case (which)
      0: cfg_wr = 1;
      1: hw_wr = 1;
      2: axis_wr = 1;
      3: legacy_wr = 1;
      default: cfg_rd = 1;
    endcase
    @(negedge clk);
    cfg_wr = 0; hw_wr = 0; axis_wr = 0; legacy_wr = 0; cfg_rd = 0;
  endtask

  task automatic wait_ready(output bit seen);
    seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      if (cfg_rdata[7]) seen = 1;
      else @(negedge clk);
    end
  endtask

  // measurement with comparator of axis i high for n[i] edges after the start edge
  task automatic measure(input int n0, input int n1, input int n2, input int n3);
    int n [4];
    int mx;
    n[0] = n0; n[1] = n1; n[2] = n2; n[3] = n3;
    mx = 0;
    for (int i = 0; i < 4; i++) if (n[i] > mx) mx = n[i];
    @(negedge clk);
    cmp_in = 4'hF;
    axis_wr = 1;
    @(negedge clk);
    axis_wr = 0;
    for (int i = 0; i < 4; i++) if (n[i] == 0) cmp_in[i] = 1'b0;
    for (int k = 1; k <= mx; k++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (n[i] == k) cmp_in[i] = 1'b0;
    end
  endtask

  task automatic check_results(input logic [3:0] en, input logic [1:0] code,
                               input int n0, input int n1, input int n2, input int n3,
                               input string req);
    int n [4];
    n[0] = n0; n[1] = n1; n[2] = n2; n[3] = n3;
    for (int i = 0; i < 4; i++) begin
      strobe_wr(0, {2'b00, 2'(i), en});
      check(req, axis_rdata, en[i] ? exp_count(n[i], code) : 16'h0); // R3 R2
    end
  endtask

  initial begin
    bit seen;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg", cfg_rdata, 8'h00);
    check("R1 hw", hw_rdata, 8'h00);
    check("R1 irq", irq, 1'b0);
    for (int s = 0; s < 4; s++) begin
      strobe_wr(0, {2'b00, 2'(s), 4'b0000});
      check("R1 axis", axis_rdata, 16'h0);
    end

    // R11 upper nibble zero, R7 bit 7 not writable
    strobe_wr(1, 8'hFF);
    check("R11 hw", hw_rdata, 8'h0F);
    strobe_wr(0, 8'hFF);
    check("R7 ready not writable", cfg_rdata, 8'h7F);
    strobe_wr(0, 8'h00);

    // R4 R5 random measurements
    for (int it = 0; it < 24; it++) begin
      logic [3:0] en;
      logic [1:0] code;
      logic ie;
      int n0, n1, n2, n3;
      en   = 4'($urandom_range(1, 15));
      code = 2'($urandom_range(0, 3));
      ie   = 1'($urandom_range(0, 1));
      n0 = $urandom_range(0, 450); n1 = $urandom_range(0, 450);
      n2 = $urandom_range(0, 450); n3 = $urandom_range(0, 450);
      strobe_wr(1, {5'b0, code, ie});
      strobe_wr(0, {4'b0000, en});
      measure(n0, n1, n2, n3);
      wait_ready(seen);
      check("R7 ready set", seen, 1'b1);
      check("R8 irq on done", irq, ie);
      check_results(en, code, n0, n1, n2, n3, "R4 R5 count");
      strobe_wr(4, 8'h00);
      check("R7 read clears ready", cfg_rdata[7], 1'b0);
      check("R7 read clears irq", irq, 1'b0);
    end

    // directed: rate boundaries
    strobe_wr(1, 8'h06);  // code 11 -> 200
    strobe_wr(0, 8'h0F);
    measure(199, 200, 399, 400);
    wait_ready(seen);
    check_results(4'hF, 2'b11, 199, 200, 399, 400, "R5 div200 edge");
    strobe_wr(4, 8'h00);
    strobe_wr(1, 8'h02);  // code 01 -> 20
    strobe_wr(0, 8'h0F);
    measure(19, 20, 0, 41);
    wait_ready(seen);
    check_results(4'hF, 2'b01, 19, 20, 0, 41, "R5 div20 edge");
    strobe_wr(4, 8'h00);

    // R6 saturation at full rate
    strobe_wr(1, 8'h00);
    strobe_wr(0, 8'h05);
    measure(66000, 65535, 70000, 3);
    wait_ready(seen);
    check("R6 ready", seen, 1'b1);
    check_results(4'h5, 2'b00, 66000, 65535, 70000, 3, "R6 saturate");
    strobe_wr(4, 8'h00);

    // R9 continuous mode
    strobe_wr(1, 8'h01);
    strobe_wr(0, 8'h41);
    @(negedge clk); cmp_in = 4'h0;
    strobe_wr(2, 8'h00);
    wait_ready(seen);
    check("R9 first done", seen, 1'b1);
    strobe_wr(4, 8'h00);
    wait_ready(seen);
    check("R9 restart gives new ready", seen, 1'b1);
    check("R9 irq again", irq, 1'b1);
    strobe_wr(0, 8'h01);
    repeat (10) @(negedge clk);
    strobe_wr(4, 8'h00);
    repeat (10) @(negedge clk);
    check("R9 no completion after clear", cfg_rdata[7], 1'b0);
    check("R9 irq quiet", irq, 1'b0);

    // R10 legacy write gating
    strobe_wr(1, 8'h01);           // ie, legacy disabled
    strobe_wr(0, 8'h02);
    strobe_wr(3, 8'h00);
    check("R10 legacy disabled", irq, 1'b0);
    strobe_wr(1, 8'h09);           // ie + legacy enable
    strobe_wr(0, 8'h00);           // no axis enabled
    strobe_wr(3, 8'h00);
    check("R10 no axis enabled", irq, 1'b0);
    strobe_wr(1, 8'h08);           // legacy enable, no ie
    strobe_wr(0, 8'h04);
    strobe_wr(3, 8'h00);
    check("R10 no ie", irq, 1'b0);
    strobe_wr(1, 8'h09);
    strobe_wr(3, 8'h00);
    check("R10 legacy irq", irq, 1'b1);
    strobe_wr(4, 8'h00);
    check("R10 irq cleared", irq, 1'b0);

    // R8 completion with ie off keeps irq low
    strobe_wr(1, 8'h00);
    strobe_wr(0, 8'h03);
    measure(5, 9, 0, 0);
    wait_ready(seen);
    check("R8 no irq without ie", irq, 1'b0);
    check_results(4'h3, 2'b00, 5, 9, 0, 0, "R2 R4 small");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule